// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing

This block is a first-in first-out buffer between two unrelated clock domains. Words enter on the write port (port A, clock `a_clk`) and leave on the read port (port B, clock `b_clk`). The storage is a power-of-two deep register array. The write and read pointers cross between domains as Gray code through two-flop synchronizers.

The read timing mode is taken from `b_mode` while the read-side reset is held, and it cannot change afterwards. In fall-through mode the block moves the oldest word into the output register by itself, and `b_flag` means "output ready". In standard mode `b_flag` means "not empty", and a word reaches the output register only when an explicit read is made. The almost-empty threshold is sampled from `b_ae_level` in the same way. `a_ready` reports a free location to the writer.

Each port takes a transfer only when all four of its qualifiers agree: chip select low, direction select asserted, enable high and mailbox select low. The port's flag must also be high. Each domain has its own asynchronous active-low reset.

Top module: `xclk_fifo`

## Requirements
- R1: A write happens on a rising `a_clk` edge only when `a_cs_n`=0, `a_wsel`=1, `a_en`=1, `a_mbx`=0 and `a_ready`=1. Accepted words come out in the order they were written, with no loss and no duplication.
- R2: A read is accepted on a rising `b_clk` edge only when `b_cs_n`=0, `b_rsel`=1, `b_en`=1, `b_mbx`=0 and `b_flag`=1. If any qualifier is wrong, `b_data` does not change and no word is consumed.
- R3: `a_ready` is 0 once the memory holds DEPTH words. A write attempted while it is 0 is dropped and never appears at the output.
- R4: A read attempted while `b_flag` is 0 is ignored, and `b_data` keeps its previous value.
- R5: In fall-through mode (`b_mode`=1 at reset), a word written into an empty FIFO appears on `b_data` at the third rising `b_clk` edge after the write. `b_flag` rises on that same edge, and no read is needed.
- R6: In standard mode (`b_mode`=0 at reset), `b_flag` rises on the second rising `b_clk` edge after a write into an empty FIFO. `b_data` changes only on a later accepted read.
- R7: After a read frees a location in a full FIFO, `a_ready` is still 0 after the first rising `a_clk` edge and is 1 after the second.
- R8: In fall-through mode, a read that takes the last word drops `b_flag` to 0, and `b_data` keeps that word.
- R9: `b_ae_n` is 0 while the read side counts `b_ae_level` words or fewer, and 1 when it counts more. The count is the memory words plus, in fall-through mode, the word held in the output register.
- R10: `b_mode` and `b_ae_level` are used only while `b_rst_n` is 0. Changing them later has no effect.
- R11: After reset, `a_ready`=1, `b_flag`=0, `b_ae_n`=0 and `b_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Write-side clock |
| a_rst_n | input | 1 | Write-side asynchronous reset, active low |
| a_cs_n | input | 1 | Write chip select, active low |
| a_wsel | input | 1 | Write direction select, 1 = write |
| a_en | input | 1 | Write enable |
| a_mbx | input | 1 | Write mailbox select, must be 0 to reach the FIFO |
| a_data | input | DATA_W | Write data |
| a_ready | output | 1 | Full / input-ready flag, 1 = a location is free |
| b_clk | input | 1 | Read-side clock |
| b_rst_n | input | 1 | Read-side asynchronous reset, active low |
| b_mode | input | 1 | Read timing mode sampled in reset: 1 fall-through, 0 standard |
| b_ae_level | input | clog2(DEPTH)+1 | Almost-empty threshold, sampled in reset |
| b_cs_n | input | 1 | Read chip select, active low |
| b_rsel | input | 1 | Read direction select, 1 = read |
| b_en | input | 1 | Read enable |
| b_mbx | input | 1 | Read mailbox select, must be 0 to reach the FIFO |
| b_data | output | DATA_W | Output register |
| b_flag | output | 1 | Empty / output-ready flag |
| b_ae_n | output | 1 | Almost-empty flag, 0 = at or below threshold |

## Verification
The assertions assume that each reset is held across at least one edge of its own clock. They also assume that the qualifiers and write data are steady around every rising edge of their port clock, and that the mode and threshold inputs are settled before the read reset is released. The stimulus drives every input on the falling edge of its own clock and returns the qualifiers to idle a fraction of a nanosecond after the rising edge. The two clock periods are chosen so that their rising edges never coincide, which makes each edge count after a write or a read unambiguous.

// File: rtl/xcf_pkg.sv
package xcf_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FALL = 1'b1
    } rd_mode_e;

    // A port reaches the FIFO only when all four qualifiers agree.
    function automatic logic port_go(input logic cs_n, input logic dir_ok,
                                     input logic en, input logic mbx);
        return !cs_n && dir_ok && en && !mbx;
    endfunction

endpackage

// File: rtl/xcf_sync.sv
module xcf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/xcf_mem.sv
module xcf_mem #(
    parameter int DW = 36,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/xcf_wr_ctl.sv
module xcf_wr_ctl #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [AW:0]   rptr_gs_i,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [AW:0]   wptr_g_o,
    output logic          ready_o
);
    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
    } wst_t;

    wst_t q, d;
    logic full;

    always_comb begin
        d = q;
        // Full: same address, opposite wrap; in Gray code the top two bits differ.
        full = (q.gray == {~rptr_gs_i[AW:AW-1], rptr_gs_i[AW-2:0]});
        we_o = req_i && !full;
        if (we_o) d.bin = q.bin + (AW+1)'(1);
        d.gray = d.bin ^ (d.bin >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign waddr_o  = q.bin[AW-1:0];
    assign wptr_g_o = q.gray;
    assign ready_o  = !full;
endmodule

// File: rtl/xcf_rd_ctl.sv
module xcf_rd_ctl
    import xcf_pkg::*;
#(
    parameter int DW = 36,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic [AW:0]   level_i,
    input  logic          req_i,
    input  logic [AW:0]   wptr_gs_i,
    input  logic [DW-1:0] mem_q_i,
    output logic [AW-1:0] raddr_o,
    output logic [AW:0]   rptr_g_o,
    output logic [DW-1:0] data_o,
    output logic          flag_o,
    output logic          ae_n_o,
    output logic          fwft_o
);
    typedef struct packed {
        logic [AW:0]   bin;
        logic [AW:0]   gray;
        rd_mode_e      mode;
        logic [AW:0]   level;
        logic          ovalid;
        logic [DW-1:0] dout;
    } rst_t;

    rst_t q, d, rst_v;
    logic          mem_ne, take, load, fall;
    logic [AW:0]   wbin, words;
    logic [AW+1:0] held;

    always_comb begin
        rst_v       = '0;
        rst_v.mode  = rd_mode_e'(mode_i);
        rst_v.level = level_i;

        for (int i = 0; i <= AW; i++) wbin[i] = ^(wptr_gs_i >> i);

        d      = q;
        fall   = (q.mode == MODE_FALL);
        mem_ne = (wptr_gs_i != q.gray);
        words  = wbin - q.bin;

        if (fall) begin
            take = req_i && q.ovalid;
            load = mem_ne && (!q.ovalid || take);
        end else begin
            take = req_i && mem_ne;
            load = take;
        end

        if (load) begin
            d.dout   = mem_q_i;
            d.bin    = q.bin + (AW+1)'(1);
            d.ovalid = fall;
        end else if (take) begin
            d.ovalid = 1'b0;
        end
        d.gray = d.bin ^ (d.bin >> 1);

        held = {1'b0, words} + (AW+2)'(fall && q.ovalid);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= rst_v;
        else        q <= d;
    end

    assign raddr_o  = q.bin[AW-1:0];
    assign rptr_g_o = q.gray;
    assign data_o   = q.dout;
    assign flag_o   = fall ? q.ovalid : mem_ne;
    assign ae_n_o   = held > {1'b0, q.level};
    assign fwft_o   = fall;
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
    import xcf_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int DEPTH  = 16
) (
    input  logic                     a_clk,
    input  logic                     a_rst_n,
    input  logic                     a_cs_n,
    input  logic                     a_wsel,
    input  logic                     a_en,
    input  logic                     a_mbx,
    input  logic [DATA_W-1:0]        a_data,
    output logic                     a_ready,
    input  logic                     b_clk,
    input  logic                     b_rst_n,
    input  logic                     b_mode,
    input  logic [$clog2(DEPTH):0]   b_ae_level,
    input  logic                     b_cs_n,
    input  logic                     b_rsel,
    input  logic                     b_en,
    input  logic                     b_mbx,
    output logic [DATA_W-1:0]        b_data,
    output logic                     b_flag,
    output logic                     b_ae_n
);
    localparam int AW = $clog2(DEPTH);

    logic [AW:0]     wptr_g, wptr_gs, rptr_g, rptr_gs;
    logic [AW-1:0]   waddr, raddr;
    logic [DATA_W-1:0] mem_q;
    logic            we, rd_fwft;

    xcf_wr_ctl #(.AW(AW)) u_wr (
        .clk      (a_clk),
        .rst_n    (a_rst_n),
        .req_i    (port_go(a_cs_n, a_wsel, a_en, a_mbx)),
        .rptr_gs_i(rptr_gs),
        .we_o     (we),
        .waddr_o  (waddr),
        .wptr_g_o (wptr_g),
        .ready_o  (a_ready)
    );

    xcf_mem #(.DW(DATA_W), .AW(AW)) u_mem (
        .clk  (a_clk),
        .we   (we),
        .waddr(waddr),
        .wdata(a_data),
        .raddr(raddr),
        .rdata(mem_q)
    );

    xcf_sync #(.W(AW+1)) u_w2r (
        .clk  (b_clk),
        .rst_n(b_rst_n),
        .d    (wptr_g),
        .q    (wptr_gs)
    );

    xcf_sync #(.W(AW+1)) u_r2w (
        .clk  (a_clk),
        .rst_n(a_rst_n),
        .d    (rptr_g),
        .q    (rptr_gs)
    );

    xcf_rd_ctl #(.DW(DATA_W), .AW(AW)) u_rd (
        .clk      (b_clk),
        .rst_n    (b_rst_n),
        .mode_i   (b_mode),
        .level_i  (b_ae_level),
        .req_i    (port_go(b_cs_n, b_rsel, b_en, b_mbx)),
        .wptr_gs_i(wptr_gs),
        .mem_q_i  (mem_q),
        .raddr_o  (raddr),
        .rptr_g_o (rptr_g),
        .data_o   (b_data),
        .flag_o   (b_flag),
        .ae_n_o   (b_ae_n),
        .fwft_o   (rd_fwft)
    );
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk
    import xcf_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int DEPTH  = 16
) (
    input logic                      a_clk,
    input logic                      a_rst_n,
    input logic                      a_ready,
    input logic [$clog2(DEPTH):0]    wptr_g,
    input logic [$clog2(DEPTH):0]    rptr_gs,
    input logic                      b_clk,
    input logic                      b_rst_n,
    input logic                      b_cs_n,
    input logic                      b_rsel,
    input logic                      b_en,
    input logic                      b_mbx,
    input logic                      b_flag,
    input logic [DATA_W-1:0]         b_data,
    input logic                      rd_fwft
);
    localparam int AW = $clog2(DEPTH);

    logic [AW:0] wb, rb, wocc;
    logic        b_req;

    always_comb begin
        for (int i = 0; i <= AW; i++) begin
            wb[i] = ^(wptr_g >> i);
            rb[i] = ^(rptr_gs >> i);
        end
        wocc  = wb - rb;
        b_req = port_go(b_cs_n, b_rsel, b_en, b_mbx);
    end

    AST_WR_BLOCKED: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        !a_ready |=> $stable(wptr_g));                                        // R3
    AST_NO_OVERFLOW: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        (32'(wocc) <= 32'(DEPTH)));                                           // R1
    AST_WPTR_ONE_BIT: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        $countones(wptr_g ^ $past(wptr_g)) <= 1);                             // R1
    AST_RD_BLOCKED_STD: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        (!rd_fwft && !b_flag) |=> $stable(b_data));                           // R4
    AST_FALL_HOLD: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        (rd_fwft && b_flag && !b_req) |=> (b_flag && $stable(b_data)));       // R2
endmodule

bind xclk_fifo xclk_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .a_clk  (a_clk),
    .a_rst_n(a_rst_n),
    .a_ready(a_ready),
    .wptr_g (wptr_g),
    .rptr_gs(rptr_gs),
    .b_clk  (b_clk),
    .b_rst_n(b_rst_n),
    .b_cs_n (b_cs_n),
    .b_rsel (b_rsel),
    .b_en   (b_en),
    .b_mbx  (b_mbx),
    .b_flag (b_flag),
    .b_data (b_data),
    .rd_fwft(rd_fwft)
);

// File: tb/xclk_fifo_test.sv
`timescale 1ns/1ps
module xclk_fifo_test;
    localparam int DW = 36;
    localparam int DEPTH = 16;
    localparam int AW = $clog2(DEPTH);

    logic a_clk = 0, b_clk = 0;
    logic a_rst_n = 0, b_rst_n = 0;
    logic a_cs_n = 1, a_wsel = 0, a_en = 0, a_mbx = 0;
    logic [DW-1:0] a_data = '0;
    logic a_ready;
    logic b_mode = 0;
    logic [AW:0] b_ae_level = '0;
    logic b_cs_n = 1, b_rsel = 0, b_en = 0, b_mbx = 0;
    logic [DW-1:0] b_data;
    logic b_flag, b_ae_n;

    int tests = 0, fails = 0;
    logic [DW-1:0] q[$];
    logic last_took;
    logic [DW-1:0] front_before;

    always #2 a_clk = ~a_clk;
    initial begin
        #1.75;
        forever #3.3 b_clk = ~b_clk;
    end

    xclk_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) uut (.*);

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_a();
        a_cs_n = 1; a_wsel = 0; a_en = 0; a_mbx = 0;
    endtask

    task automatic idle_b();
        b_cs_n = 1; b_rsel = 0; b_en = 0; b_mbx = 0;
    endtask

    task automatic reset_dut(input logic mode, input int level);
        a_rst_n = 0; b_rst_n = 0;
        b_mode = mode; b_ae_level = (AW+1)'(level);
        idle_a(); idle_b();
        q.delete();
        repeat (3) @(posedge b_clk);
        @(negedge a_clk) a_rst_n = 1;
        @(negedge b_clk) b_rst_n = 1;
        b_mode = ~mode;                 // R10: later changes must not matter
        b_ae_level = '0;
        repeat (2) @(posedge b_clk);
        #0.3;
    endtask

    task automatic wr_word(input logic [DW-1:0] w, input logic cs_n = 0,
                           input logic wsel = 1, input logic en = 1, input logic mbx = 0);
        @(negedge a_clk);
        a_data = w; a_cs_n = cs_n; a_wsel = wsel; a_en = en; a_mbx = mbx;
        if (!cs_n && wsel && en && !mbx && a_ready) q.push_back(w);
        @(posedge a_clk);
        fork begin #0.2; idle_a(); end join_none
    endtask

    task automatic rd_try(input logic cs_n = 0, input logic rsel = 1,
                          input logic en = 1, input logic mbx = 0);
        @(negedge b_clk);
        b_cs_n = cs_n; b_rsel = rsel; b_en = en; b_mbx = mbx;
        last_took = !cs_n && rsel && en && !mbx && b_flag;
        front_before = b_data;
        @(posedge b_clk);
        fork begin #0.2; idle_b(); end join_none
    endtask

    task automatic wait_b(input int n);
        repeat (n) @(posedge b_clk);
        #0.3;
    endtask

    task automatic pop_std(input string req);
        rd_try();
        chk(req, "std read taken", DW'(last_took), DW'(1));
        #0.3;
        chk(req, "std read data", b_data, q.pop_front());
    endtask

    task automatic pop_fall(input string req);
        rd_try();
        chk(req, "fall read taken", DW'(last_took), DW'(1));
        chk(req, "fall head data", front_before, q.pop_front());
    endtask

    task automatic t_reset();
        reset_dut(0, 3);
        chk("R11", "ready after reset", DW'(a_ready), DW'(1));
        chk("R11", "flag after reset", DW'(b_flag), DW'(0));
        chk("R11", "ae_n after reset", DW'(b_ae_n), DW'(0));
        chk("R11", "data after reset", b_data, '0);
    endtask

    task automatic t_qualifiers();
        reset_dut(0, 3);
        wr_word(36'h111, 1, 1, 1, 0);
        wr_word(36'h222, 0, 0, 1, 0);
        wr_word(36'h333, 0, 1, 0, 0);
        wr_word(36'h444, 0, 1, 1, 1);
        wait_b(5);
        chk("R1", "flag after unqualified writes", DW'(b_flag), DW'(0));
        wr_word(36'hA1);
        wr_word(36'hA2);
        wait_b(5);
        rd_try(1, 1, 1, 0); #0.3; chk("R2", "data after cs_n high", b_data, '0);
        rd_try(0, 0, 1, 0); #0.3; chk("R2", "data after rsel low", b_data, '0);
        rd_try(0, 1, 0, 0); #0.3; chk("R2", "data after en low", b_data, '0);
        rd_try(0, 1, 1, 1); #0.3; chk("R2", "data after mbx high", b_data, '0);
        pop_std("R1");
        pop_std("R2");
    endtask

    task automatic t_std_latency();
        reset_dut(0, 3);
        rd_try();
        chk("R4", "read on empty taken", DW'(last_took), DW'(0));
        #0.3;
        chk("R4", "data after empty read", b_data, '0);
        wr_word(36'h5A5A5);
        @(posedge b_clk); #0.3;
        chk("R6", "flag at edge 1", DW'(b_flag), DW'(0));
        @(posedge b_clk); #0.3;
        chk("R6", "flag at edge 2", DW'(b_flag), DW'(1));
        chk("R10", "no fall-through load at edge 2", b_data, '0);
        wait_b(2);
        chk("R6", "data without read", b_data, '0);
        pop_std("R6");
    endtask

    task automatic t_fall_latency();
        reset_dut(1, 3);
        wr_word(36'hC0FFEE);
        @(posedge b_clk); #0.3;
        chk("R5", "flag at edge 1", DW'(b_flag), DW'(0));
        @(posedge b_clk); #0.3;
        chk("R5", "flag at edge 2", DW'(b_flag), DW'(0));
        @(posedge b_clk); #0.3;
        chk("R5", "flag at edge 3", DW'(b_flag), DW'(1));
        chk("R10", "data at edge 3", b_data, 36'hC0FFEE);
        pop_fall("R8");
        #0.3;
        chk("R8", "flag after last read", DW'(b_flag), DW'(0));
        chk("R8", "data kept", b_data, 36'hC0FFEE);
        rd_try();
        chk("R4", "read on low flag taken", DW'(last_took), DW'(0));
        #0.3;
        chk("R4", "data after ignored read", b_data, 36'hC0FFEE);
    endtask

    task automatic t_full_release();
        reset_dut(0, 3);
        for (int i = 0; i < DEPTH; i++) wr_word(DW'(36'h100 + i));
        #0.3;
        chk("R3", "ready when full", DW'(a_ready), DW'(0));
        wr_word(36'hBAD);
        wait_b(4);
        rd_try();
        fork
            begin
                #0.3;
                chk("R7", "read from full", b_data, q.pop_front());
            end
            begin
                @(posedge a_clk); #0.3;
                chk("R7", "ready at edge 1", DW'(a_ready), DW'(0));
                @(posedge a_clk); #0.3;
                chk("R7", "ready at edge 2", DW'(a_ready), DW'(1));
            end
        join
        for (int i = 0; i < DEPTH - 1; i++) pop_std("R3");
        wait_b(4);
        chk("R3", "flag after drain", DW'(b_flag), DW'(0));
    endtask

    task automatic t_almost_empty();
        reset_dut(0, 3);
        for (int i = 0; i < 3; i++) wr_word(DW'(36'h200 + i));
        wait_b(4);
        chk("R9", "std ae_n at level", DW'(b_ae_n), DW'(0));
        wr_word(36'h203);
        wait_b(4);
        chk("R9", "std ae_n above level", DW'(b_ae_n), DW'(1));
        reset_dut(1, 3);
        for (int i = 0; i < 4; i++) wr_word(DW'(36'h300 + i));
        wait_b(5);
        chk("R9", "fall ae_n with 4 held", DW'(b_ae_n), DW'(1));
        pop_fall("R9");
        #0.3;
        chk("R9", "fall ae_n with 3 held", DW'(b_ae_n), DW'(0));
    endtask

    task automatic t_stream();
        reset_dut(1, 2);
        fork
            for (int i = 0; i < 12; i++) begin
                wr_word(DW'(36'h9000 + i * 7));
                if (i % 3 == 0) @(posedge a_clk);
            end
            begin
                int got = 0;
                while (got < 12) begin
                    rd_try();
                    if (last_took) begin
                        chk("R1", "stream order", front_before, q.pop_front());
                        got++;
                    end
                end
            end
        join
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_qualifiers();
        t_std_latency();
        t_fall_latency();
        t_full_release();
        t_almost_empty();
        t_stream();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule